// File: doc/BRIEF.md
# Two-Port Memory with Collision Arbitration

A synchronous 2048-word by 8-bit memory with two independent access ports, called left and right. Each port has its own select, write strobe, read strobe, 11-bit address, write data and registered read data. Both ports may read or write any word in the same clock cycle. All controls are active high.

An arbiter watches both ports. It flags a collision when both ports are selected and their addresses are equal. The port that was settled on that address first keeps access. The other port gets a busy flag, and its writes are dropped inside the block. The arbiter looks only at select and address, so a read collides exactly as a write does. Each busy flag is a port output. Several slices of this memory can therefore share one arbiter decision, or a system can treat busy as a warning of a collision.

A port is "settled" in a cycle if it was selected in the previous cycle with the same address. It is "fresh" if its select has just risen or its address has just changed. If both ports are fresh when the collision starts, a parameter fixes the winner. By default the left port wins.

Top module: `dual_port_arb_ram`

## Requirements
- R1: Every one of the 2048 words can be written from either port and read back from either port. Read data appears on the port in the cycle after the read is presented.
- R2: The read-valid output is high in a cycle exactly when that port had select=1, read strobe=1 and write strobe=0 in the previous cycle. Otherwise read-valid is 0 and read data is 0.
- R3: A port changes memory only when its select and its write strobe are both 1. A write strobe with select=0 leaves memory unchanged.
- R4: A busy flag is 1 only if, in the previous cycle, both selects were 1 and the two addresses were equal. A busy flag is 0 in the cycle after either select is 0 or the addresses differ.
- R5: When a collision starts, a settled port wins over a fresh port, and the fresh port gets busy. A port counts as fresh after its select rises or after its address changes.
- R6: When both ports are fresh in the first cycle of a collision, the left port wins by default (parameter LEFT_TIE_WINS=1), and the right port gets busy.
- R7: The write and read strobes have no effect on which port is granted.
- R8: The left and right busy flags are never 1 in the same cycle.
- R9: A write from the losing port is dropped in every cycle of the collision, including the first one. The winning port's write takes effect.
- R10: The grant stays with the same port for as long as both selects stay 1 and the addresses stay equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_ce | input | 1 | Left port select |
| l_we | input | 1 | Left port write strobe |
| l_oe | input | 1 | Left port read strobe |
| l_addr | input | 11 | Left port word address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port read data (registered) |
| l_rvalid | output | 1 | Left port read data valid |
| l_busy | output | 1 | Left port lost arbitration |
| r_ce | input | 1 | Right port select |
| r_we | input | 1 | Right port write strobe |
| r_oe | input | 1 | Right port read strobe |
| r_addr | input | 11 | Right port word address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port read data (registered) |
| r_rvalid | output | 1 | Right port read data valid |
| r_busy | output | 1 | Right port lost arbitration |

## Verification
Read data, read-valid and both busy flags are due one clock edge after the inputs that cause them. A write is visible to a read presented at any later edge. A read at the same edge as a write returns the old word. The bench drives each input set, waits for exactly one rising edge, and samples two nanoseconds later. Each result is therefore compared against the inputs of the edge just passed. Losing writes are checked by reading the word back through a port in a later cycle. The comparison uses a bench-side model array of 2048 words that is filled by a full sweep.

// File: rtl/dpr_pkg.sv
// Package: types and default sizes for the two-port arbitrated memory.
// Assumes: port index 0 is the left port and index 1 is the right port.
package dpr_pkg;
    localparam int unsigned DPR_ADDR_W = 11;
    localparam int unsigned DPR_DATA_W = 8;
    localparam int unsigned DPR_PORTS  = 2;

    // Which port currently holds the contended word.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/dpr_arbiter.sv
// Module: dpr_arbiter
// Detects an address collision between the two ports and decides which
// port keeps access. A port is fresh in a cycle if its select just rose or
// its address just changed. At the start of a collision the settled port
// wins; if both ports are fresh, LEFT_TIE_WINS decides. The grant is held
// while the collision lasts. lose is combinational and gates writes at the
// same edge; busy is the registered copy of lose, seen one cycle later.
// Assumes: only select and address matter; the strobes are not inputs here.
module dpr_arbiter
    import dpr_pkg::*;
#(
    parameter int unsigned AW            = 11,
    parameter bit          LEFT_TIE_WINS = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_l,
    input  logic          ce_r,
    input  logic [AW-1:0] addr_l,
    input  logic [AW-1:0] addr_r,
    output logic [1:0]    lose,
    output logic [1:0]    busy
);
    logic          prev_ce_l, prev_ce_r;
    logic [AW-1:0] prev_addr_l, prev_addr_r;
    logic          fresh_l, fresh_r, match;
    owner_e        owner_q, owner_nxt;

    // Inputs from the previous cycle, used to tell settled ports from fresh ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ce_l   <= 1'b0;
            prev_ce_r   <= 1'b0;
            prev_addr_l <= '0;
            prev_addr_r <= '0;
        end else begin
            prev_ce_l   <= ce_l;
            prev_ce_r   <= ce_r;
            prev_addr_l <= addr_l;
            prev_addr_r <= addr_r;
        end
    end

    // Collision condition and the freshness of each port in this cycle.
    always_comb begin
        match   = ce_l && ce_r && (addr_l == addr_r);
        fresh_l = !prev_ce_l || (prev_addr_l != addr_l);
        fresh_r = !prev_ce_r || (prev_addr_r != addr_r);
    end

    // Owner for this edge: hold an existing grant, otherwise settled beats fresh.
    always_comb begin
        if (!match)
            owner_nxt = OWN_NONE;
        else if (owner_q != OWN_NONE)
            owner_nxt = owner_q;
        else if (!fresh_l && fresh_r)
            owner_nxt = OWN_LEFT;
        else if (fresh_l && !fresh_r)
            owner_nxt = OWN_RIGHT;
        else
            owner_nxt = LEFT_TIE_WINS ? OWN_LEFT : OWN_RIGHT;
    end

    assign lose[0] = (owner_nxt == OWN_RIGHT);
    assign lose[1] = (owner_nxt == OWN_LEFT);

    // Grant state and the registered busy flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= OWN_NONE;
            busy    <= 2'b00;
        end else begin
            owner_q <= owner_nxt;
            busy    <= lose;
        end
    end

    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy[0] && busy[1])); // R8
    AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[0] || busy[1]) |-> $past(ce_l && ce_r && (addr_l == addr_r))); // R4
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce_l && ce_r && (addr_l == addr_r)) |=> (busy == 2'b00)); // R4
    AST_GRANT_HELD_R: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[1] && ce_l && ce_r && (addr_l == addr_r)) |=> busy[1]); // R10
    AST_GRANT_HELD_L: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[0] && ce_l && ce_r && (addr_l == addr_r)) |=> busy[0]); // R10
endmodule

// File: rtl/dpr_port_ctl.sv
// Module: dpr_port_ctl
// Decodes one port's controls into a write enable, which is blocked while
// the port loses arbitration, and a read enable.
// Assumes: lose comes from the arbiter for the same clock edge.
module dpr_port_ctl (
    input  logic ce,
    input  logic we,
    input  logic oe,
    input  logic lose,
    output logic wen,
    output logic ren
);
    // Write needs select and strobe and no lost collision; read needs select, read strobe and no write.
    always_comb begin
        wen = ce && we && !lose;
        ren = ce && oe && !we;
    end
endmodule

// File: rtl/dpr_store.sv
// Module: dpr_store
// Word array with one write path and one registered read path per port.
// A read at the same edge as a write to the same word returns the old word.
// Read data is forced to zero when no read was issued.
// Assumes: the two write enables never target the same word together.
module dpr_store #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 8,
    parameter int unsigned NP = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NP-1:0]         wen,
    input  logic [NP-1:0]         ren,
    input  logic [NP-1:0][AW-1:0] addr,
    input  logic [NP-1:0][DW-1:0] wdata,
    output logic [NP-1:0][DW-1:0] rdata,
    output logic [NP-1:0]         rvalid
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Apply the enabled writes of all ports.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (wen[p])
                mem[addr[p]] <= wdata[p];
        end
    end

    for (genvar g = 0; g < NP; g++) begin : g_rd
        // Registered read path of port g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[g]  <= '0;
                rvalid[g] <= 1'b0;
            end else begin
                rvalid[g] <= ren[g];
                rdata[g]  <= ren[g] ? mem[addr[g]] : '0;
            end
        end
    end

    AST_NO_SHARED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wen[0] && wen[1]) |-> (addr[0] != addr[1])); // R9
endmodule

// File: rtl/dual_port_arb_ram.sv
// Module: dual_port_arb_ram
// Top of the two-port memory: two port decoders, the collision arbiter and
// the word array. Busy and read data are registered and appear one cycle
// after the inputs that cause them.
// Assumes: all inputs are synchronous to clk; the reset is synchronous and active low.
module dual_port_arb_ram
    import dpr_pkg::*;
#(
    parameter int unsigned AW            = DPR_ADDR_W,
    parameter int unsigned DW            = DPR_DATA_W,
    parameter bit          LEFT_TIE_WINS = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_ce,
    input  logic          l_we,
    input  logic          l_oe,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_rvalid,
    output logic          l_busy,
    input  logic          r_ce,
    input  logic          r_we,
    input  logic          r_oe,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_rvalid,
    output logic          r_busy
);
    localparam int unsigned NP = DPR_PORTS;

    logic [NP-1:0]         ce_v, we_v, oe_v, lose_v, busy_v, wen_v, ren_v, rvalid_v;
    logic [NP-1:0][AW-1:0] addr_v;
    logic [NP-1:0][DW-1:0] wdata_v, rdata_v;

    assign ce_v    = {r_ce, l_ce};
    assign we_v    = {r_we, l_we};
    assign oe_v    = {r_oe, l_oe};
    assign addr_v  = {r_addr, l_addr};
    assign wdata_v = {r_wdata, l_wdata};

    dpr_arbiter #(.AW(AW), .LEFT_TIE_WINS(LEFT_TIE_WINS)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .ce_l(l_ce), .ce_r(r_ce), .addr_l(l_addr), .addr_r(r_addr),
        .lose(lose_v), .busy(busy_v)
    );

    for (genvar g = 0; g < NP; g++) begin : g_port
        dpr_port_ctl u_ctl (
            .ce(ce_v[g]), .we(we_v[g]), .oe(oe_v[g]), .lose(lose_v[g]),
            .wen(wen_v[g]), .ren(ren_v[g])
        );
    end

    dpr_store #(.AW(AW), .DW(DW), .NP(NP)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wen(wen_v), .ren(ren_v), .addr(addr_v), .wdata(wdata_v),
        .rdata(rdata_v), .rvalid(rvalid_v)
    );

    assign l_rdata  = rdata_v[0];
    assign r_rdata  = rdata_v[1];
    assign l_rvalid = rvalid_v[0];
    assign r_rvalid = rvalid_v[1];
    assign l_busy   = busy_v[0];
    assign r_busy   = busy_v[1];

    AST_LRVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        l_rvalid |-> $past(l_ce && l_oe && !l_we)); // R2
    AST_RRVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_rvalid |-> $past(r_ce && r_oe && !r_we)); // R2
    AST_BUSY_IGNORES_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce || !r_ce) |=> (!l_busy && !r_busy)); // R4
endmodule

// File: tb/dual_port_arb_ram_bench.sv
module dual_port_arb_ram_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l_ce = 0, l_we = 0, l_oe = 0, r_ce = 0, r_we = 0, r_oe = 0;
    logic [10:0] l_addr = '0, r_addr = '0;
    logic [7:0]  l_wdata = '0, r_wdata = '0;
    logic [7:0]  l_rdata, r_rdata;
    logic        l_rvalid, r_rvalid, l_busy, r_busy;

    int total = 0;
    int bad   = 0;
    logic [7:0] ref_mem [2048];

    always #4 clk = ~clk;

    dual_port_arb_ram u_dual_port_arb_ram (
        .clk(clk), .rst_n(rst_n),
        .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_busy(l_busy),
        .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_busy(r_busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One rising edge, then sample; exclusion of busy flags checked every cycle (R8).
    task automatic cyc();
        @(posedge clk);
        #2;
        chk("R8", "both busy", int'(l_busy && r_busy), 0);
    endtask

    task automatic idle();
        l_ce = 0; l_we = 0; l_oe = 0;
        r_ce = 0; r_we = 0; r_oe = 0;
        cyc();
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 8));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(); cyc();
        chk("R4", "reset l_busy", int'(l_busy), 0);
        chk("R4", "reset r_busy", int'(r_busy), 0);
        chk("R2", "reset l_rvalid", int'(l_rvalid), 0);
        chk("R2", "reset r_rvalid", int'(r_rvalid), 0);
        rst_n = 1'b1;
        idle();

        // R1: fill all words, even from left, odd from right, in the same cycles.
        for (int a = 0; a < 1024; a++) begin
            l_ce = 1; l_we = 1; l_addr = 11'(2*a);   l_wdata = pat(2*a);
            r_ce = 1; r_we = 1; r_addr = 11'(2*a+1); r_wdata = pat(2*a+1);
            ref_mem[2*a] = pat(2*a); ref_mem[2*a+1] = pat(2*a+1);
            cyc();
            chk("R4", "busy on distinct write", int'(l_busy || r_busy), 0);
        end
        // R1: read every word back from both ports, in opposite orders.
        l_we = 0; r_we = 0; l_oe = 1; r_oe = 1;
        for (int a = 0; a < 2048; a++) begin
            l_addr = 11'(a); r_addr = 11'(2047 - a);
            cyc();
            chk("R1", "left read", int'(l_rdata), int'(ref_mem[a]));
            chk("R1", "right read", int'(r_rdata), int'(ref_mem[2047-a]));
            chk("R2", "left valid", int'(l_rvalid), 1);
        end
        idle();

        // R2 and R3: the read-valid rules, and a write with select low.
        l_ce = 1; l_oe = 0; l_we = 0; l_addr = 11'd700;
        cyc();
        chk("R2", "valid without oe", int'(l_rvalid), 0);
        chk("R2", "data without oe", int'(l_rdata), 0);
        l_oe = 1; l_we = 1; l_wdata = 8'h99; ref_mem[700] = 8'h99;
        cyc();
        chk("R2", "valid during write", int'(l_rvalid), 0);
        l_ce = 0; l_we = 0;
        cyc();
        chk("R2", "valid without ce", int'(l_rvalid), 0);
        l_ce = 0; l_we = 1; l_addr = 11'd600; l_wdata = ~ref_mem[600];
        r_ce = 1; r_oe = 1; r_addr = 11'd600;
        cyc();
        chk("R4", "equal addr one ce off busy", int'(l_busy || r_busy), 0);
        cyc();
        chk("R3", "write with ce low ignored", int'(r_rdata), int'(ref_mem[600]));
        r_addr = 11'd700; l_we = 0;
        cyc();
        chk("R3", "write with ce high stored", int'(r_rdata), 8'h99);
        idle();

        // R5, R9, R10: left settled at 100, right arrives later with a write.
        l_ce = 1; l_oe = 1; l_addr = 11'd100;
        cyc();
        chk("R4", "single port busy", int'(l_busy || r_busy), 0);
        r_ce = 1; r_we = 1; r_addr = 11'd100; r_wdata = ~ref_mem[100];
        cyc();
        chk("R5", "late right gets busy", int'(r_busy), 1);
        chk("R5", "settled left not busy", int'(l_busy), 0);
        cyc();
        chk("R10", "grant held", int'(r_busy), 1);
        chk("R9", "first-cycle losing write dropped", int'(l_rdata), int'(ref_mem[100]));
        cyc();
        chk("R9", "losing write still dropped", int'(l_rdata), int'(ref_mem[100]));
        l_addr = 11'd101; ref_mem[100] = r_wdata;
        cyc();
        chk("R4", "busy drops after mismatch", int'(r_busy || l_busy), 0);
        l_ce = 0; r_we = 0; r_oe = 1;
        cyc();
        chk("R9", "write after collision lands", int'(r_rdata), int'(ref_mem[100]));
        idle();

        // R6: both fresh on 200 together, both writing.
        l_ce = 1; l_we = 1; l_addr = 11'd200; l_wdata = 8'hA5;
        r_ce = 1; r_we = 1; r_addr = 11'd200; r_wdata = 8'h5A;
        ref_mem[200] = 8'hA5;
        cyc();
        chk("R6", "tie right busy", int'(r_busy), 1);
        chk("R6", "tie left free", int'(l_busy), 0);
        l_ce = 0; l_we = 0; r_we = 0; r_oe = 1;
        cyc();
        chk("R6", "tie winner data", int'(r_rdata), 8'hA5);
        idle();

        // R5 reversed: right settled on 300, left arrives with a write.
        r_ce = 1; r_oe = 1; r_addr = 11'd300;
        cyc();
        l_ce = 1; l_we = 1; l_addr = 11'd300; l_wdata = ~ref_mem[300];
        cyc();
        chk("R5", "late left gets busy", int'(l_busy), 1);
        chk("R5", "settled right free", int'(r_busy), 0);
        l_ce = 0; l_we = 0;
        cyc();
        cyc();
        chk("R9", "left losing write dropped", int'(r_rdata), int'(ref_mem[300]));
        idle();

        // R5 by address change: both selected, left moves onto right's word.
        l_ce = 1; l_oe = 1; l_addr = 11'd400;
        r_ce = 1; r_oe = 1; r_addr = 11'd401;
        cyc();
        l_oe = 0; l_we = 1; l_addr = 11'd401; l_wdata = ~ref_mem[401];
        cyc();
        chk("R5", "address mover gets busy", int'(l_busy), 1);
        chk("R5", "steady port free", int'(r_busy), 0);
        l_ce = 0; l_we = 0;
        cyc();
        cyc();
        chk("R9", "mover write dropped", int'(r_rdata), int'(ref_mem[401]));
        idle();

        // R7: strobes swapped relative to the 100 case, same arbitration outcome.
        l_ce = 1; l_we = 1; l_addr = 11'd500; l_wdata = 8'h11; ref_mem[500] = 8'h11;
        cyc();
        l_we = 0; l_oe = 0;
        r_ce = 1; r_oe = 1; r_addr = 11'd500;
        cyc();
        chk("R7", "read-only latecomer busy", int'(r_busy), 1);
        chk("R7", "winner not busy", int'(l_busy), 0);
        chk("R7", "busy port still reads", int'(r_rdata), 8'h11);
        idle();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule